// File: doc/BRIEF.md
# SECDED Memory Read Checker

This block sits between a non-volatile memory array and the read path of a bus. Each stored word is 72 bits wide: 64 data bits guarded by 8 check bits of an extended Hamming code. The checker samples the raw word together with its address when a read is requested. It waits a programmable number of wait states and then returns the data. Any single flipped bit is repaired before the data goes out. Two flipped bits are detected and raised as a non-maskable fault.

For error reporting, the block keeps a correction flag, a detection flag and the address of the first failing double word. A small register port lets software set the wait states and the correction-interrupt enable, read the flags and the captured address, and clear the flags by writing ones. A freshly erased word reads as all ones, so a double upset in such a word is treated as erased data and is not reported as a fault.

Top module: `nvm_secded_reader`

## Requirements
- R1: Codeword layout: bit 0 is the overall parity, chosen so that all 72 bits XOR to zero. Bit positions 1, 2, 4, 8, 16, 32 and 64 are check bits. Data bit i is held at the i-th position in ascending order among the remaining positions 3..71. The check bit at position 2^j is the XOR of every other position whose index has bit j set. A clean word is returned unchanged and raises no flag.
- R2: A single flipped bit at any position 0..71 is corrected on `rd_data` and sets the correction flag. A flip in a check bit or in the parity bit leaves the data output unchanged.
- R3: Two flipped bits set the detection flag. The same applies to an odd-parity word whose syndrome points beyond position 71. `nmi_fault` is high exactly while the detection flag is set.
- R4: `corr_irq` is high while the correction flag is set and the enable bit (control register bit 8) is one.
- R5: On a reported error, when both flags were clear before the event, the failing address is captured with bits [2:0] forced to zero. The captured address reads back in status bits [28:8].
- R6: While either flag is set, later errors do not change the captured address. Capture resumes only once both flags are clear.
- R7: A word with exactly two zero bits among its 72 is taken as erased data. It returns all-ones data and raises no flag and no fault. A word with a single zero bit is corrected as in R2.
- R8: The wait-state count N sits in control bits [3:0]. `rd_valid` pulses for one cycle on the (N+1)-th clock edge counted from the edge that samples `rd_req`. `rd_data`, the flags and the address update on that same edge. The word and address are held from the sampling edge, and requests that arrive while an access is pending are ignored.
- R9: Writing the status register (`csr_sel`=1) with bit 0 set clears the correction flag, and with bit 1 set clears the detection flag. Zero bits leave the flags alone. If an error event lands on the same edge as a clear, the flag stays set.
- R10: After reset, both flags and the captured address are zero, the wait-state count is 1, the interrupt enable is 0, and `rd_valid`, `corr_irq` and `nmi_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Read request, sampled on the rising edge |
| rd_addr | input | 21 | Byte address of the read |
| rd_word | input | 72 | Raw stored codeword from the array |
| rd_valid | output | 1 | One-cycle pulse when read data is ready |
| rd_data | output | 64 | Corrected read data |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 1 | Register select: 0 control, 1 status |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data of the selected register |
| corr_irq | output | 1 | Correction interrupt |
| nmi_fault | output | 1 | Non-maskable fault for a detected double error |

## Verification
The bench builds the block with its default parameters: a 21-bit address and a 4-bit wait-state field. It programs wait states from 0 to 5. That range reaches both the zero-wait path, where the raw word is decoded on the sampling edge itself, and the counted path, where the word must be held in place while the input changes. Random data, with single flips at any of the 72 positions and double flips, is mixed with directed cases:
- erased words with one or two zero bits,
- a flag clear landing on the completion edge,
- a second request arriving during a pending access,
- a sequence of errors at several addresses that shows the captured address staying frozen and then being recaptured.

// File: rtl/nvm_secded_pkg.sv
`timescale 1ns/1ps
package nvm_secded_pkg;

    localparam int DATA_W = 64;
    localparam int CODE_W = 72;
    localparam int SYN_W  = 7;

    // Outcome of decoding one codeword
    typedef struct packed {
        logic corr;
        logic det;
    } ecc_event_t;

    // Position in the codeword of data bit idx: the idx-th non-power-of-two index
    function automatic int data_pos(input int idx);
        int n;
        int found;
        n     = 0;
        found = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (n == idx) found = p;
                n++;
            end
        end
        return found;
    endfunction

endpackage

// File: rtl/secded_decode.sv
`timescale 1ns/1ps
module secded_decode
    import nvm_secded_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] data_o,
    output ecc_event_t        ev_o
);

    logic [SYN_W-1:0]  syn;
    logic              par_odd;
    logic              erased_two;
    logic [CODE_W-1:0] flip;
    logic [CODE_W-1:0] fixed;
    logic [DATA_W-1:0] extracted;
    logic              raw_det;

    always_comb begin
        syn = '0;
        for (int p = 1; p < CODE_W; p++) begin
            if (code_i[p]) syn = syn ^ SYN_W'(p);
        end
        par_odd    = ^code_i;
        erased_two = ($countones(code_i) == CODE_W - 2);
        flip       = '0;
        ev_o.corr  = 1'b0;
        raw_det    = 1'b0;
        if (par_odd) begin
            if (int'(syn) < CODE_W) begin
                ev_o.corr = 1'b1;
                flip      = CODE_W'(1) << syn;
            end else begin
                raw_det = 1'b1;
            end
        end else if (syn != '0) begin
            raw_det = 1'b1;
        end
        // erased word with two upsets is not reported
        ev_o.det = raw_det && !erased_two;
        fixed    = code_i ^ flip;
        data_o   = (raw_det && erased_two) ? '1 : extracted;
    end

    for (genvar g = 0; g < DATA_W; g++) begin : g_extract
        localparam int POS = data_pos(g);
        assign extracted[g] = fixed[POS];
    end

    always_comb begin
        p_corr_det_exclusive_r3: assert (!(ev_o.corr && ev_o.det));
    end

endmodule

// File: rtl/read_pacer.sv
`timescale 1ns/1ps
module read_pacer
    import nvm_secded_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int WS_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CODE_W-1:0] word_i,
    input  logic [WS_W-1:0]   ws_i,
    output logic              fire_o,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [CODE_W-1:0] cur_word_o,
    output logic              valid_o
);

    typedef struct packed {
        logic              busy;
        logic [WS_W-1:0]   cnt;
        logic [ADDR_W-1:0] addr;
        logic [CODE_W-1:0] word;
        logic              valid;
    } pacer_t;

    pacer_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        fire_o     = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                fire_o     = 1'b1;
                st_d.busy  = 1'b0;
                st_d.valid = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (req_i) begin
            st_d.addr = addr_i;
            st_d.word = word_i;
            if (ws_i == '0) begin
                fire_o     = 1'b1;
                st_d.valid = 1'b1;
            end else begin
                st_d.busy = 1'b1;
                st_d.cnt  = ws_i - 1'b1;
            end
        end
    end

    assign cur_addr_o = st_q.busy ? st_q.addr : addr_i;
    assign cur_word_o = st_q.busy ? st_q.word : word_i;
    assign valid_o    = st_q.valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_no_valid_while_waiting_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != '0) |=> !st_q.valid);

    p_word_held_while_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !fire_o) |=> $stable(st_q.word) && $stable(st_q.addr));

endmodule

// File: rtl/ecc_status.sv
`timescale 1ns/1ps
module ecc_status
    import nvm_secded_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ecc_event_t        ev_i,
    input  logic [ADDR_W-1:0] ev_addr_i,
    input  logic              clr_corr_i,
    input  logic              clr_det_i,
    output logic              corr_o,
    output logic              det_o,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] LOW_MASK = ~ADDR_W'(7);

    typedef struct packed {
        logic              corr;
        logic              det;
        logic [ADDR_W-1:0] addr;
    } stat_t;

    stat_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr_corr_i) st_d.corr = 1'b0;
        if (clr_det_i)  st_d.det  = 1'b0;
        if (ev_i.corr)  st_d.corr = 1'b1;
        if (ev_i.det)   st_d.det  = 1'b1;
        if ((ev_i.corr || ev_i.det) && !st_q.corr && !st_q.det)
            st_d.addr = ev_addr_i & LOW_MASK;
    end

    assign corr_o = st_q.corr;
    assign det_o  = st_q.det;
    assign addr_o = st_q.addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_addr_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.corr || st_q.det) |=> $stable(st_q.addr));

    p_addr_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.addr[2:0] == 3'b000);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i.corr |=> st_q.corr);

    p_det_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.det && !clr_det_i) |=> st_q.det);

endmodule

// File: rtl/nvm_secded_reader.sv
`timescale 1ns/1ps
module nvm_secded_reader
    import nvm_secded_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int WS_W       = 4,
    parameter int WS_RESET   = 1,
    parameter int CSR_W      = 32,
    parameter int IRQ_EN_BIT = 8,
    parameter int ADDR_LSB   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CODE_W-1:0] rd_word,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              csr_we,
    input  logic              csr_sel,
    input  logic [CSR_W-1:0]  csr_wdata,
    output logic [CSR_W-1:0]  csr_rdata,
    output logic              corr_irq,
    output logic              nmi_fault
);

    typedef struct packed {
        logic [WS_W-1:0]   ws;
        logic              irq_en;
        logic [DATA_W-1:0] data;
    } top_t;

    top_t st_q, st_d;

    logic              fire;
    logic [ADDR_W-1:0] cur_addr;
    logic [CODE_W-1:0] cur_word;
    logic [DATA_W-1:0] dec_data;
    ecc_event_t        dec_ev;
    ecc_event_t        gated_ev;
    logic              flag_corr, flag_det;
    logic [ADDR_W-1:0] cap_addr;
    logic              clr_corr, clr_det;
    logic              wdata_unused;

    read_pacer #(.ADDR_W(ADDR_W), .WS_W(WS_W)) u_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (rd_req),
        .addr_i     (rd_addr),
        .word_i     (rd_word),
        .ws_i       (st_q.ws),
        .fire_o     (fire),
        .cur_addr_o (cur_addr),
        .cur_word_o (cur_word),
        .valid_o    (rd_valid)
    );

    secded_decode u_decode (
        .code_i (cur_word),
        .data_o (dec_data),
        .ev_o   (dec_ev)
    );

    assign gated_ev.corr = fire && dec_ev.corr;
    assign gated_ev.det  = fire && dec_ev.det;
    assign clr_corr      = csr_we && csr_sel && csr_wdata[0];
    assign clr_det       = csr_we && csr_sel && csr_wdata[1];
    assign wdata_unused  = ^csr_wdata;

    ecc_status #(.ADDR_W(ADDR_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (gated_ev),
        .ev_addr_i  (cur_addr),
        .clr_corr_i (clr_corr),
        .clr_det_i  (clr_det),
        .corr_o     (flag_corr),
        .det_o      (flag_det),
        .addr_o     (cap_addr)
    );

    always_comb begin
        st_d = st_q;
        if (fire) st_d.data = dec_data;
        if (csr_we && !csr_sel) begin
            st_d.ws     = csr_wdata[WS_W-1:0];
            st_d.irq_en = csr_wdata[IRQ_EN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.ws     <= WS_W'(WS_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        csr_rdata = '0;
        if (!csr_sel) begin
            csr_rdata[WS_W-1:0]  = st_q.ws;
            csr_rdata[IRQ_EN_BIT] = st_q.irq_en;
        end else begin
            csr_rdata[0]                 = flag_corr;
            csr_rdata[1]                 = flag_det;
            csr_rdata[ADDR_LSB +: ADDR_W] = cap_addr;
        end
    end

    assign rd_data   = st_q.data;
    assign corr_irq  = flag_corr && st_q.irq_en;
    assign nmi_fault = flag_det;

    p_fault_after_double_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gated_ev.det |=> nmi_fault);

    p_valid_after_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> rd_valid);

endmodule

// File: tb/nvm_secded_reader_tb.sv
`timescale 1ns/1ps
module nvm_secded_reader_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic [20:0] rd_addr = '0;
    logic [71:0] rd_word = '0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        csr_we = 1'b0;
    logic        csr_sel = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        corr_irq;
    logic        nmi_fault;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model
    int          m_ws = 1;
    bit          m_en = 0;
    bit          m_corr = 0;
    bit          m_det = 0;
    logic [20:0] m_addr = '0;

    always #5 clk = ~clk;

    nvm_secded_reader u_dut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_word(rd_word), .rd_valid(rd_valid), .rd_data(rd_data),
        .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .corr_irq(corr_irq), .nmi_fault(nmi_fault)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [71:0] enc(input logic [63:0] d);
        logic [71:0] c;
        logic [6:0]  s;
        int k;
        c = '0; s = '0; k = 0;
        for (int p = 1; p < 72; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p] = d[k];
                if (d[k]) s = s ^ 7'(p);
                k++;
            end
        end
        for (int j = 0; j < 7; j++) c[1 << j] = s[j];
        c[0] = ^c[71:1];
        return c;
    endfunction

    task automatic csr_write(input bit sel, input logic [31:0] wd);
        @(negedge clk);
        csr_we = 1'b1; csr_sel = sel; csr_wdata = wd;
        @(negedge clk);
        csr_we = 1'b0;
        if (!sel) begin
            m_ws = int'(wd[3:0]);
            m_en = wd[8];
        end else begin
            if (wd[0]) m_corr = 0;
            if (wd[1]) m_det = 0;
        end
    endtask

    task automatic check_status(input string tag);
        csr_sel = 1'b1;
        #1;
        chk(csr_rdata[0] == m_corr, {tag, " R2 corr flag"}, 64'(csr_rdata[0]), 64'(m_corr));
        chk(csr_rdata[1] == m_det, {tag, " R3 det flag"}, 64'(csr_rdata[1]), 64'(m_det));
        chk(csr_rdata[28:8] == m_addr, {tag, " R5 R6 captured addr"}, 64'(csr_rdata[28:8]), 64'(m_addr));
        chk(nmi_fault == m_det, {tag, " R3 nmi"}, 64'(nmi_fault), 64'(m_det));
        chk(corr_irq == (m_corr && m_en), {tag, " R4 irq"}, 64'(corr_irq), 64'(m_corr && m_en));
    endtask

    // kind: 0 clean, 1 single corrected, 2 double detected, 3 erased suppressed
    task automatic do_read(input logic [20:0] a, input logic [71:0] w, input int kind,
                           input logic [63:0] exp_d, input string tag);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = a; rd_word = w;
        @(negedge clk);
        rd_req = 1'b0; rd_addr = 21'($urandom); rd_word = {$urandom, $urandom, $urandom};
        for (int k = 0; k <= m_ws; k++) begin
            if (k > 0) @(negedge clk);
            if (k < m_ws) chk(rd_valid == 1'b0, {tag, " R8 early valid"}, 64'(rd_valid), 64'd0);
        end
        chk(rd_valid == 1'b1, {tag, " R8 valid on time"}, 64'(rd_valid), 64'd1);
        if (kind == 1 || kind == 2) begin
            if (!m_corr && !m_det) m_addr = {a[20:3], 3'b000};
            if (kind == 1) m_corr = 1;
            if (kind == 2) m_det = 1;
        end
        if (kind != 2)
            chk(rd_data == exp_d, {tag, " R1 R2 R7 data"}, rd_data, exp_d);
        check_status(tag);
        @(negedge clk);
        chk(rd_valid == 1'b0, {tag, " R8 single pulse"}, 64'(rd_valid), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        logic [71:0] w;
        int p1, p2, mode;
        void'($urandom(32'h1f2e3d4c));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        csr_sel = 1'b0; #1;
        chk(csr_rdata[3:0] == 4'd1, "R10 ws reset", 64'(csr_rdata[3:0]), 64'd1);
        chk(csr_rdata[8] == 1'b0, "R10 irq enable reset", 64'(csr_rdata[8]), 64'd0);
        chk(rd_valid == 1'b0, "R10 valid reset", 64'(rd_valid), 64'd0);
        check_status("R10 reset");

        // R1 clean word, default latency
        d = 64'h0123_4567_89ab_cdef;
        do_read(21'h00_1234, enc(d), 0, d, "R1 clean");

        // R2 parity bit only and check bit only
        csr_write(1'b0, 32'h0000_0100);
        w = enc(d); w[0] = ~w[0];
        do_read(21'h00_0015, w, 1, d, "R2 parity bit flip");
        w = enc(d); w[32] = ~w[32];
        do_read(21'h00_0029, w, 1, d, "R2 check bit flip");
        csr_write(1'b1, 32'h3);

        // R7 erased: one zero corrected, two zeros suppressed
        csr_write(1'b0, 32'h0000_0000);
        w = '1; w[45] = 1'b0;
        do_read(21'h1f_fff8, w, 1, '1, "R7 erased single");
        csr_write(1'b1, 32'h1);
        w = '1; w[3] = 1'b0; w[70] = 1'b0;
        do_read(21'h1f_fff0, w, 3, '1, "R7 erased double");
        w = '1; w[0] = 1'b0; w[64] = 1'b0;
        do_read(21'h1f_ffe0, w, 3, '1, "R7 erased double check bits");

        // R6 capture freeze and resume
        d = 64'hdead_beef_cafe_f00d;
        w = enc(d); w[10] = ~w[10];
        do_read(21'h0a_aaaf, w, 1, d, "R6 first error");
        w = enc(d); w[10] = ~w[10]; w[20] = ~w[20];
        do_read(21'h05_5557, w, 2, d, "R6 second error frozen");
        csr_write(1'b1, 32'h1);
        check_status("R6 after corr clear");
        w = enc(d); w[50] = ~w[50];
        do_read(21'h12_3457, w, 1, d, "R6 still frozen");
        csr_write(1'b1, 32'h2);
        check_status("R9 zero bit no effect");
        csr_write(1'b1, 32'h1);
        w = enc(d); w[7] = ~w[7];
        do_read(21'h0c_0ffe, w, 1, d, "R6 recapture");

        // R9 set wins over a clear on the same edge (ws=1)
        csr_write(1'b1, 32'h3);
        csr_write(1'b0, 32'h0000_0001);
        d = 64'h5555_aaaa_0f0f_f0f0;
        w = enc(d); w[33] = ~w[33];
        @(negedge clk);
        rd_req = 1'b1; rd_addr = 21'h01_0203; rd_word = w;
        @(negedge clk);
        rd_req = 1'b0; csr_we = 1'b1; csr_sel = 1'b1; csr_wdata = 32'h3;
        @(negedge clk);
        csr_we = 1'b0;
        m_corr = 1; m_addr = 21'h01_0200;
        chk(rd_valid == 1'b1, "R9 valid with clear", 64'(rd_valid), 64'd1);
        chk(rd_data == d, "R9 data with clear", rd_data, d);
        check_status("R9 set wins");
        csr_write(1'b1, 32'h3);

        // R8 request during a pending access is ignored (ws=3)
        csr_write(1'b0, 32'h0000_0003);
        d = 64'h1357_9bdf_0246_8ace;
        @(negedge clk);
        rd_req = 1'b1; rd_addr = 21'h00_0100; rd_word = enc(d);
        @(negedge clk);
        rd_addr = 21'h00_0200; rd_word = enc(~d) ^ 72'h3;
        @(negedge clk);
        rd_req = 1'b0; rd_word = '0;
        begin
            int pulses = 0;
            for (int k = 0; k < 8; k++) begin
                if (rd_valid) begin
                    pulses++;
                    chk(rd_data == d, "R8 first request data", rd_data, d);
                end
                @(negedge clk);
            end
            chk(pulses == 1, "R8 one pulse only", 64'(pulses), 64'd1);
        end
        check_status("R8 ignored request");

        // random mix
        for (int it = 0; it < 400; it++) begin
            if ($urandom_range(0, 7) == 0)
                csr_write(1'b0, {23'd0, 1'($urandom), 4'd0, 4'($urandom_range(0, 5))});
            if ($urandom_range(0, 3) == 0)
                csr_write(1'b1, 32'($urandom_range(0, 3)));
            d = {$urandom, $urandom};
            w = enc(d);
            mode = $urandom_range(0, 2);
            p1 = $urandom_range(0, 71);
            p2 = (p1 + $urandom_range(1, 71)) % 72;
            if (mode >= 1) w[p1] = ~w[p1];
            if (mode == 2) w[p2] = ~w[p2];
            do_read(21'($urandom), w, mode, d, $sformatf("R2 R3 random %0d", it));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule